// File: doc/BRIEF.md
# Clipping Flag Register Unit

This unit keeps the 24-bit clipping-judgement flag history of a vector coprocessor and runs the four instructions that work on it. An external comparison stage, which is not part of this unit, sends 6-bit clip results. Each result moves the history up by one 6-bit group and enters at the bottom, so the register holds the last four results. The oldest result is pushed out at the top.

Instructions arrive as 32-bit words with a valid strobe. The opcode sits in bits [31:25] and the 24-bit immediate in bits [23:0]. A load instruction overwrites the whole history with the immediate. Two test instructions compare the history with a mask. One asks whether any masked bit is set. The other asks whether the history ORed with the mask fills all 24 bits. Both write a 0/1 result to integer register 1. A read instruction copies the low 12 history bits into an integer register chosen by the instruction. All integer results leave through a registered writeback port.

Top module: `clipflag_unit`

## Requirements
- R1: A synchronous active-low reset clears the flag register to zero and drives `wb_en` low. Reset takes priority over every other input.
- R2: A valid word with opcode bits [31:25] = 0x11 loads bits [23:0] into the flag register. The new value appears after the next rising edge, and no writeback follows.
- R3: A valid word with opcode 0x12 produces, one edge later, `wb_en`=1, `wb_idx`=1, and `wb_data`=1 if (flags AND bits[23:0]) is nonzero, otherwise 0. The flag register is unchanged.
- R4: A valid word with opcode 0x13 produces, one edge later, `wb_en`=1, `wb_idx`=1, and `wb_data`=1 only if (flags OR bits[23:0]) equals 0xFFFFFF, otherwise 0. The flag register is unchanged.
- R5: A valid word with opcode 0x1C produces, one edge later, `wb_en`=1, `wb_idx`=bits[20:16], and `wb_data`=flags[11:0] zero-extended to 16 bits.
- R6: When `clip_valid` is high, the flag register becomes {flags[17:0], clip_bits} after the edge. The top 6 bits are discarded.
- R7: When a load (R2) and `clip_valid` occur in the same cycle, the load value is taken and the clip result is lost.
- R8: Tests and reads use the flag value held before the edge. An instruction in the same cycle as a clip sees the old history. An instruction in the following cycle sees the shifted history.
- R9: A word with `insn_valid` low, or with any other opcode, causes no writeback (`wb_en`=0 one edge later). It also leaves the flag register unchanged when no clip result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Instruction word: opcode [31:25], index [20:16], immediate [23:0] |
| clip_valid | input | 1 | Clip result is valid this cycle |
| clip_bits | input | 6 | New 6-bit clip result |
| flags_q | output | 24 | Current flag register |
| wb_en | output | 1 | Integer writeback strobe |
| wb_idx | output | 5 | Integer register index for the writeback |
| wb_data | output | 16 | Writeback value |

## Verification
All results are registered once. Flag changes from a load or a clip, and every writeback, become visible after exactly one rising edge following the input cycle. The bench drives inputs on a falling edge and samples on the next falling edge, so each result is checked in the one cycle it is due. The R8 vectors place a clip and a test in the same cycle, then a test in the following cycle. This separates the value held before the edge from the value after it. A writeback strobe is checked one edge after every stimulus, so that a missing or extra strobe is seen.

// File: rtl/clipflag_pkg.sv
// Package: shared widths, opcodes and decoded operation type for the
// clipping flag unit. Assumes a 32-bit instruction word.
package clipflag_pkg;

    localparam int INSN_W = 32;
    localparam int OPC_W  = 7;
    localparam int OPC_LSB = 25;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 7'h11;
    localparam logic [OPC_W-1:0] OPC_ANYT  = 7'h12;
    localparam logic [OPC_W-1:0] OPC_FULLT = 7'h13;
    localparam logic [OPC_W-1:0] OPC_READ  = 7'h1C;

    typedef enum logic [2:0] {
        CF_NONE  = 3'd0,
        CF_LOAD  = 3'd1,
        CF_ANYT  = 3'd2,
        CF_FULLT = 3'd3,
        CF_READ  = 3'd4
    } cf_op_e;

endpackage

// File: rtl/clipflag_decode.sv
// Decoder: turns a valid instruction word into an operation kind, the
// immediate mask and the destination index. Pure combinational logic.
// Assumes the opcode field occupies the top OPC_W bits of the word.
module clipflag_decode
    import clipflag_pkg::*;
#(
    parameter int FLAG_W = 24,
    parameter int IDX_W  = 5,
    parameter int IDX_LSB = 16
) (
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn_word,
    output cf_op_e            op,
    output logic [FLAG_W-1:0] imm,
    output logic [IDX_W-1:0]  idx
);
    logic [OPC_W-1:0] opc;
    logic             unused_bits;

    assign opc = insn_word[OPC_LSB +: OPC_W];
    assign imm = insn_word[FLAG_W-1:0];
    assign idx = insn_word[IDX_LSB +: IDX_W];
    assign unused_bits = ^insn_word;

    // Map the opcode field to an operation; invalid words decode to none.
    always_comb begin
        op = CF_NONE;
        if (insn_valid) begin
            case (opc)
                OPC_LOAD:  op = CF_LOAD;
                OPC_ANYT:  op = CF_ANYT;
                OPC_FULLT: op = CF_FULLT;
                OPC_READ:  op = CF_READ;
                default:   op = CF_NONE;
            endcase
        end
    end
endmodule

// File: rtl/clipflag_store.sv
// Flag history register: a load overwrites it, otherwise a clip result
// shifts it up by one group. Assumes FLAG_W is a multiple of CLIP_W.
module clipflag_store #(
    parameter int FLAG_W = 24,
    parameter int CLIP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [FLAG_W-1:0] load_val,
    input  logic              shift_en,
    input  logic [CLIP_W-1:0] shift_in,
    output logic [FLAG_W-1:0] flags
);
    localparam int GROUPS = FLAG_W / CLIP_W;

    logic [FLAG_W-1:0] shifted;

    // Each group takes the one below it; group 0 takes the new result.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        if (g == 0) begin : g_bottom
            assign shifted[CLIP_W-1:0] = shift_in;
        end else begin : g_upper
            assign shifted[g*CLIP_W +: CLIP_W] = flags[(g-1)*CLIP_W +: CLIP_W];
        end
    end

    // Register update: reset, then load, then shift, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (load_en) begin
            flags <= load_val;
        end else if (shift_en) begin
            flags <= shifted;
        end
    end
endmodule

// File: rtl/clipflag_eval.sv
// Evaluator: runs the two flag tests and the flag read against the
// current history and registers the integer writeback. Assumes the
// writeback is wider than the read field.
module clipflag_eval
    import clipflag_pkg::*;
#(
    parameter int FLAG_W   = 24,
    parameter int IDX_W    = 5,
    parameter int DATA_W   = 16,
    parameter int READ_W   = 12,
    parameter int TEST_IDX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cf_op_e            op,
    input  logic [FLAG_W-1:0] imm,
    input  logic [IDX_W-1:0]  idx,
    input  logic [FLAG_W-1:0] flags,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data
);
    localparam logic [IDX_W-1:0] TEST_SEL = IDX_W'(TEST_IDX);

    logic              any_hit;
    logic              all_full;
    logic              do_wb;
    logic [IDX_W-1:0]  nxt_idx;
    logic [DATA_W-1:0] nxt_data;

    assign any_hit  = |(flags & imm);
    assign all_full = &(flags | imm);

    // Choose destination and value for the operation in flight.
    always_comb begin
        do_wb    = 1'b0;
        nxt_idx  = wb_idx;
        nxt_data = wb_data;
        case (op)
            CF_ANYT: begin
                do_wb    = 1'b1;
                nxt_idx  = TEST_SEL;
                nxt_data = DATA_W'(any_hit);
            end
            CF_FULLT: begin
                do_wb    = 1'b1;
                nxt_idx  = TEST_SEL;
                nxt_data = DATA_W'(all_full);
            end
            CF_READ: begin
                do_wb    = 1'b1;
                nxt_idx  = idx;
                nxt_data = {{(DATA_W-READ_W){1'b0}}, flags[READ_W-1:0]};
            end
            default: begin
                do_wb    = 1'b0;
            end
        endcase
    end

    // Register the writeback port one edge after the instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en   <= 1'b0;
            wb_idx  <= '0;
            wb_data <= '0;
        end else begin
            wb_en   <= do_wb;
            wb_idx  <= nxt_idx;
            wb_data <= nxt_data;
        end
    end
endmodule

// File: rtl/clipflag_unit.sv
// Top: clipping flag register unit. Decodes flag instructions, keeps the
// clip history and writes test and read results to the integer port.
// Assumes at most one instruction and one clip result per cycle.
module clipflag_unit
    import clipflag_pkg::*;
#(
    parameter int FLAG_W   = 24,
    parameter int CLIP_W   = 6,
    parameter int IDX_W    = 5,
    parameter int DATA_W   = 16,
    parameter int READ_W   = 12,
    parameter int TEST_IDX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [31:0]       insn_word,
    input  logic              clip_valid,
    input  logic [CLIP_W-1:0] clip_bits,
    output logic [FLAG_W-1:0] flags_q,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data
);
    cf_op_e            dec_op;
    logic [FLAG_W-1:0] dec_imm;
    logic [IDX_W-1:0]  dec_idx;

    clipflag_decode #(
        .FLAG_W(FLAG_W), .IDX_W(IDX_W), .IDX_LSB(16)
    ) u_dec (
        .insn_valid(insn_valid), .insn_word(insn_word),
        .op(dec_op), .imm(dec_imm), .idx(dec_idx)
    );

    clipflag_store #(
        .FLAG_W(FLAG_W), .CLIP_W(CLIP_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .load_en(dec_op == CF_LOAD), .load_val(dec_imm),
        .shift_en(clip_valid), .shift_in(clip_bits),
        .flags(flags_q)
    );

    clipflag_eval #(
        .FLAG_W(FLAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
        .READ_W(READ_W), .TEST_IDX(TEST_IDX)
    ) u_eval (
        .clk(clk), .rst_n(rst_n),
        .op(dec_op), .imm(dec_imm), .idx(dec_idx), .flags(flags_q),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );
endmodule

// File: rtl/clipflag_unit_sva.sv
// Checker: port-level properties of the clipping flag unit, bound to
// every instance of the top module.
module clipflag_unit_sva
    import clipflag_pkg::*;
#(
    parameter int FLAG_W   = 24,
    parameter int CLIP_W   = 6,
    parameter int IDX_W    = 5,
    parameter int DATA_W   = 16,
    parameter int READ_W   = 12,
    parameter int TEST_IDX = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_valid,
    input logic [31:0]       insn_word,
    input logic              clip_valid,
    input logic [CLIP_W-1:0] clip_bits,
    input logic [FLAG_W-1:0] flags_q,
    input logic              wb_en,
    input logic [IDX_W-1:0]  wb_idx,
    input logic [DATA_W-1:0] wb_data
);
    logic [OPC_W-1:0] opc;
    logic is_load, is_test, is_read;
    assign opc     = insn_word[OPC_LSB +: OPC_W];
    assign is_load = insn_valid && (opc == OPC_LOAD);
    assign is_test = insn_valid && (opc == OPC_ANYT || opc == OPC_FULLT);
    assign is_read = insn_valid && (opc == OPC_READ);

    assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> flags_q == $past(insn_word[FLAG_W-1:0]));

    assert_test_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_test |=> wb_en && wb_idx == IDX_W'(TEST_IDX) && wb_data[DATA_W-1:1] == '0);

    assert_read_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_read |=> wb_en && wb_idx == $past(insn_word[16 +: IDX_W])
                    && wb_data[DATA_W-1:READ_W] == '0);

    assert_clip_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clip_valid && !is_load) |=>
            flags_q == {$past(flags_q[FLAG_W-CLIP_W-1:0]), $past(clip_bits)});

    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clip_valid && !is_load) |=> $stable(flags_q));

    assert_no_stray_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_test && !is_read) |=> !wb_en);
endmodule

bind clipflag_unit clipflag_unit_sva #(
    .FLAG_W(FLAG_W), .CLIP_W(CLIP_W), .IDX_W(IDX_W),
    .DATA_W(DATA_W), .READ_W(READ_W), .TEST_IDX(TEST_IDX)
) u_sva (.*);

// File: tb/clipflag_unit_test.sv
module clipflag_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        clip_valid = 1'b0;
    logic [5:0]  clip_bits = '0;
    logic [23:0] flags_q;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [15:0] wb_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    clipflag_unit uut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .clip_valid(clip_valid), .clip_bits(clip_bits), .flags_q(flags_q),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    typedef struct packed {
        logic        iv;
        logic [31:0] word;
        logic        cv;
        logic [5:0]  cb;
        logic [23:0] ef;
        logic        ew;
        logic [4:0]  ei;
        logic [15:0] ed;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 16;
    // Opcode words: load 0x22xxxxxx, any-test 0x24xxxxxx, full-test 0x26xxxxxx, read 0x38ii0000
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h22ABCDEF, 1'b0, 6'h00, 24'hABCDEF, 1'b0, 5'd0,  16'h0000, 8'd2}, // R2
        '{1'b1, 32'h38070000, 1'b0, 6'h00, 24'hABCDEF, 1'b1, 5'd7,  16'h0DEF, 8'd5}, // R5
        '{1'b1, 32'h24000010, 1'b0, 6'h00, 24'hABCDEF, 1'b1, 5'd1,  16'h0000, 8'd3}, // R3
        '{1'b1, 32'h24800000, 1'b0, 6'h00, 24'hABCDEF, 1'b1, 5'd1,  16'h0001, 8'd3}, // R3
        '{1'b1, 32'h26543210, 1'b0, 6'h00, 24'hABCDEF, 1'b1, 5'd1,  16'h0001, 8'd4}, // R4
        '{1'b1, 32'h26543200, 1'b0, 6'h00, 24'hABCDEF, 1'b1, 5'd1,  16'h0000, 8'd4}, // R4
        '{1'b0, 32'h00000000, 1'b1, 6'h15, 24'hF37BD5, 1'b0, 5'd0,  16'h0000, 8'd6}, // R6
        '{1'b0, 32'h00000000, 1'b1, 6'h3F, 24'hDEF57F, 1'b0, 5'd0,  16'h0000, 8'd6}, // R6
        '{1'b1, 32'h381F0000, 1'b0, 6'h00, 24'hDEF57F, 1'b1, 5'd31, 16'h057F, 8'd8}, // R8
        '{1'b1, 32'h22000000, 1'b1, 6'h2A, 24'h000000, 1'b0, 5'd0,  16'h0000, 8'd7}, // R7
        '{1'b1, 32'h24FFFFFF, 1'b0, 6'h00, 24'h000000, 1'b1, 5'd1,  16'h0000, 8'd3}, // R3
        '{1'b1, 32'h26FFFFFF, 1'b0, 6'h00, 24'h000000, 1'b1, 5'd1,  16'h0001, 8'd4}, // R4
        '{1'b1, 32'h28FFFFFF, 1'b0, 6'h00, 24'h000000, 1'b0, 5'd0,  16'h0000, 8'd9}, // R9
        '{1'b0, 32'h22123456, 1'b0, 6'h00, 24'h000000, 1'b0, 5'd0,  16'h0000, 8'd9}, // R9
        '{1'b1, 32'h24000001, 1'b1, 6'h01, 24'h000001, 1'b1, 5'd1,  16'h0000, 8'd8}, // R8
        '{1'b1, 32'h24000001, 1'b0, 6'h00, 24'h000001, 1'b1, 5'd1,  16'h0001, 8'd8}  // R8
    };

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic iv, input logic [31:0] w,
                         input logic cv, input logic [5:0] cb);
        insn_valid = iv;
        insn_word  = w;
        clip_valid = cv;
        clip_bits  = cb;
        @(negedge clk);
        insn_valid = 1'b0;
        clip_valid = 1'b0;
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "flags after reset", 32'(flags_q), 32'h0);
        check("R1", "wb_en after reset", 32'(wb_en), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].rq);
            drive(VEC[i].iv, VEC[i].word, VEC[i].cv, VEC[i].cb);
            check(tag, $sformatf("vec %0d flags", i), 32'(flags_q), 32'(VEC[i].ef));
            check(tag, $sformatf("vec %0d wb_en", i), 32'(wb_en), 32'(VEC[i].ew));
            if (VEC[i].ew) begin
                check(tag, $sformatf("vec %0d wb_idx", i), 32'(wb_idx), 32'(VEC[i].ei));
                check(tag, $sformatf("vec %0d wb_data", i), 32'(wb_data), 32'(VEC[i].ed));
            end
        end

        // R6: four full groups fill the register, a fifth pushes out the oldest
        drive(1'b1, 32'h22000000, 1'b0, 6'h00);
        for (int k = 0; k < 4; k++) drive(1'b0, 32'h0, 1'b1, 6'h3F);
        check("R6", "four groups fill", 32'(flags_q), 32'hFFFFFF);
        drive(1'b0, 32'h0, 1'b1, 6'h00);
        check("R6", "oldest discarded", 32'(flags_q), 32'hFFFFC0);

        // R4: one missing bit fails the full test
        drive(1'b1, 32'h26000000, 1'b0, 6'h00);
        check("R4", "bits 5:0 clear", 32'(wb_data), 32'h0);
        drive(1'b1, 32'h2600003F, 1'b0, 6'h00);
        check("R4", "mask fills gap", 32'(wb_data), 32'h1);

        // R1: reset wins over a pending load and clip
        rst_n = 1'b0;
        drive(1'b1, 32'h24FFFFFF, 1'b1, 6'h3F);
        check("R1", "flags cleared by reset", 32'(flags_q), 32'h0);
        check("R1", "wb_en cleared by reset", 32'(wb_en), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule